// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-Down Controller

This block owns the clock-enable line of an SDRAM device. It watches the memory controller's activity and bank state and lowers clock-enable to put the device into power-down. It raises the line again when the processor port or the display-refresh port asks for memory. A 16-bit control word, written through a simple write strobe and read back at any time, selects between two entry policies. The first is immediate entry whenever the controller has nothing in flight. The second is entry only after all banks have stayed precharged and idle for a programmable number of 128-clock units.

On wake, clock-enable returns high at once. A ready output stays low for a short exit delay, so the controller knows when a new command may be issued. The block contains no command sequencing, refresh or arbitration. It only decides the state of clock-enable and reports whether the device is usable.

Top module: `sdram_cke_pwr_ctrl`

## Requirements
- R1: A write strobe loads the control word at the next clock edge. Bit 15 is the immediate-entry enable, bit 14 the timed-entry enable and bits 11..8 the timeout. The readback shows the new value from the following cycle on, and holds while no write is made.
- R2: While reset is asserted, and after it is released, the control word reads 0x0000, clock-enable is 1 and ready is 1.
- R3: Bits 13..12 and 7..0 of the control word ignore writes and always read back 0. Writing 0x30FF reads back 0x0000, and writing 0xFFFF reads back 0xCF00.
- R4: With both enables 0, clock-enable stays 1 whatever the busy, precharged and wake inputs do.
- R5: With immediate entry enabled and the device awake, clock-enable goes 0 from the first clock edge at which busy is 0 and no wake request is present.
- R6: With timed entry enabled (immediate entry off) and a timeout T of 1 or more, clock-enable goes 0 at the edge that ends exactly T*128 consecutive qualifying cycles. A qualifying cycle has busy 0, precharged 1 and no wake request, with the device awake.
- R7: The idle count restarts from zero whenever busy is 1 or precharged is 0 for a cycle, so a full T*128 run is needed afterwards.
- R8: While powered down, a CPU wake request or a display wake request raises clock-enable at the next edge. Ready is 0 in that cycle.
- R9: Ready stays 0 for exactly one cycle after wake (the exit delay), then returns to 1. Clock-enable does not drop during the exit delay.
- R10: When both enables are 1, the immediate policy wins: clock-enable drops at the first idle edge without waiting for the timeout.
- R11: A timeout field of 0 disables timed entry even when bit 14 is 1. Clock-enable stays 1 through 2100 idle precharged cycles.
- R12: A pending CPU or display wake request while the device is awake prevents entry into power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 16 | Control word write value |
| cfg_rd_data | output | 16 | Control word readback |
| ctrl_busy | input | 1 | Controller is issuing a command or moving read/write data |
| banks_precharged | input | 1 | All SDRAM banks are precharged |
| cpu_wake_req | input | 1 | Processor port wants memory |
| disp_wake_req | input | 1 | Display-refresh port wants memory |
| sdram_cke | output | 1 | SDRAM clock-enable |
| sdram_ready | output | 1 | Device awake; a command may be issued |

## Verification
The hardest case to reach is the exact edge of timed entry. The idle run must be unbroken for T*128 cycles, and an interruption one cycle before the limit must push entry out by a full period. The stimulus holds busy low and precharged high from a known cycle. It samples clock-enable one cycle before and exactly at the limit, for timeouts of 1 and 2. It then repeats the run with a single busy cycle, and then a single precharged drop, inserted partway through. A run of more than 2100 cycles with a zero timeout shows that the timed policy is truly off.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;
  localparam int CTRL_W   = 16;
  localparam int APEN_BIT = 15;
  localparam int PDEN_BIT = 14;
  localparam int TOUT_LSB = 8;
  localparam int TOUT_W   = 4;

  typedef enum logic [1:0] {
    PD_AWAKE = 2'd0,
    PD_DOWN  = 2'd1,
    PD_EXIT  = 2'd2
  } pd_state_e;
endpackage

// File: rtl/sdram_pd_cfg.sv
module sdram_pd_cfg
  import sdram_pd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              imm_en,
  output logic              timed_en,
  output logic [TOUT_W-1:0] tout,
  output logic [CTRL_W-1:0] rd_data
);
  logic              imm_q, imm_d;
  logic              timed_q, timed_d;
  logic [TOUT_W-1:0] tout_q, tout_d;
  logic              unused_rsvd;

  assign unused_rsvd = ^{wr_data[13:12], wr_data[7:0]};

  always_comb begin
    imm_d   = imm_q;
    timed_d = timed_q;
    tout_d  = tout_q;
    if (wr_en) begin
      imm_d   = wr_data[APEN_BIT];
      timed_d = wr_data[PDEN_BIT];
      tout_d  = wr_data[TOUT_LSB +: TOUT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_q   <= 1'b0;
      timed_q <= 1'b0;
      tout_q  <= '0;
    end else begin
      imm_q   <= imm_d;
      timed_q <= timed_d;
      tout_q  <= tout_d;
    end
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[APEN_BIT]              = imm_q;
    rd_data[PDEN_BIT]              = timed_q;
    rd_data[TOUT_LSB +: TOUT_W]    = tout_q;
  end

  assign imm_en   = imm_q;
  assign timed_en = timed_q;
  assign tout     = tout_q;

  // R1: a write is visible on the readback in the next cycle
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[APEN_BIT] == $past(wr_data[APEN_BIT])) &&
              (rd_data[PDEN_BIT] == $past(wr_data[PDEN_BIT])) &&
              (rd_data[TOUT_LSB +: TOUT_W] == $past(wr_data[TOUT_LSB +: TOUT_W])));

  // R1: without a write the control word holds
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/sdram_pd_idle_timer.sv
module sdram_pd_idle_timer
  import sdram_pd_pkg::*;
#(
  parameter int UNIT_CLKS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timed_en,
  input  logic              imm_en,
  input  logic [TOUT_W-1:0] tout,
  input  logic              busy,
  input  logic              precharged,
  input  logic              wake,
  input  logic              awake,
  output logic              expire
);
  localparam int MAX_LIMIT = ((1 << TOUT_W) - 1) * UNIT_CLKS;
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             qual;

  assign limit = CNT_W'(tout) * CNT_W'(UNIT_CLKS);
  assign qual  = awake && timed_en && !imm_en && (tout != '0) &&
                 !busy && precharged && !wake;

  always_comb begin
    expire = qual && (cnt_q >= limit - CNT_W'(1));
    if (!qual || expire) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: any busy cycle or lost precharge restarts the idle run
  a_r7_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || !precharged) |=> (cnt_q == '0));

  // R6: the idle count never runs past the largest timeout
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_LIMIT));
endmodule

// File: rtl/sdram_pd_fsm.sv
module sdram_pd_fsm
  import sdram_pd_pkg::*;
#(
  parameter int EXIT_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic imm_en,
  input  logic expire,
  input  logic busy,
  input  logic wake,
  output logic cke,
  output logic ready,
  output logic awake
);
  localparam int EW = (EXIT_CLKS > 1) ? $clog2(EXIT_CLKS) : 1;

  pd_state_e     state_q, state_d;
  logic [EW-1:0] ex_q, ex_d;
  logic          ex_done;

  assign ex_done = (ex_q == EW'(EXIT_CLKS - 1));

  always_comb begin
    state_d = state_q;
    ex_d    = '0;
    case (state_q)
      PD_AWAKE: begin
        if (imm_en && !busy && !wake) state_d = PD_DOWN;
        else if (expire)              state_d = PD_DOWN;
      end
      PD_DOWN: begin
        if (wake) state_d = PD_EXIT;
      end
      PD_EXIT: begin
        if (ex_done) state_d = PD_AWAKE;
        else         ex_d    = ex_q + EW'(1);
      end
      default: state_d = PD_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_AWAKE;
      ex_q    <= '0;
    end else begin
      state_q <= state_d;
      ex_q    <= ex_d;
    end
  end

  assign cke   = (state_q != PD_DOWN);
  assign ready = (state_q == PD_AWAKE);
  assign awake = ready;

  // R5: immediate entry on the first idle edge
  a_r5_imm_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && imm_en && !busy && !wake) |=> !cke);

  // R8: a wake request while down raises clock-enable, not yet ready
  a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && wake) |=> (cke && !ready));

  // R9: clock-enable never falls during the exit delay
  a_r9_exit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !ready) |=> cke);
endmodule

// File: rtl/sdram_cke_pwr_ctrl.sv
module sdram_cke_pwr_ctrl
  import sdram_pd_pkg::*;
#(
  parameter int UNIT_CLKS = 128,
  parameter int EXIT_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CTRL_W-1:0] cfg_wr_data,
  output logic [CTRL_W-1:0] cfg_rd_data,
  input  logic              ctrl_busy,
  input  logic              banks_precharged,
  input  logic              cpu_wake_req,
  input  logic              disp_wake_req,
  output logic              sdram_cke,
  output logic              sdram_ready
);
  logic              rst_meta, rst_sync_n;
  logic              imm_en, timed_en, expire, awake, wake;
  logic [TOUT_W-1:0] tout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign wake = cpu_wake_req || disp_wake_req;

  sdram_pd_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .imm_en   (imm_en),
    .timed_en (timed_en),
    .tout     (tout),
    .rd_data  (cfg_rd_data)
  );

  sdram_pd_idle_timer #(.UNIT_CLKS(UNIT_CLKS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .timed_en   (timed_en),
    .imm_en     (imm_en),
    .tout       (tout),
    .busy       (ctrl_busy),
    .precharged (banks_precharged),
    .wake       (wake),
    .awake      (awake),
    .expire     (expire)
  );

  sdram_pd_fsm #(.EXIT_CLKS(EXIT_CLKS)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .imm_en (imm_en),
    .expire (expire),
    .busy   (ctrl_busy),
    .wake   (wake),
    .cke    (sdram_cke),
    .ready  (sdram_ready),
    .awake  (awake)
  );

  // R4: with both policies off the device is never powered down
  a_r4_no_entry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_rd_data[APEN_BIT] && !cfg_rd_data[PDEN_BIT] && sdram_cke) |=> sdram_cke);

  // R12: a pending wake request blocks entry
  a_r12_wake_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sdram_cke && (cpu_wake_req || disp_wake_req)) |=> sdram_cke);

  // R10: both enabled, the immediate policy acts on the first idle edge
  a_r10_priority: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sdram_ready && cfg_rd_data[APEN_BIT] && cfg_rd_data[PDEN_BIT] &&
     !ctrl_busy && !wake) |=> !sdram_cke);
endmodule

// File: tb/sdram_cke_pwr_ctrl_test.sv
module sdram_cke_pwr_ctrl_test;
  localparam int CLK_P = 10;
  localparam int UNIT  = 128;
  localparam int NVEC  = 19;

  // {wr, wdata, busy, pre, cpu, disp, exp_cke, exp_rdy, exp_rd}
  localparam logic [38:0] VEC [0:NVEC-1] = '{
    {1'b1, 16'h8000, 4'b1000, 2'b11, 16'h8000},
    {1'b0, 16'h0000, 4'b1000, 2'b11, 16'h8000},
    {1'b0, 16'h0000, 4'b0000, 2'b00, 16'h8000},
    {1'b0, 16'h0000, 4'b0000, 2'b00, 16'h8000},
    {1'b0, 16'h0000, 4'b0010, 2'b10, 16'h8000},
    {1'b0, 16'h0000, 4'b0010, 2'b11, 16'h8000},
    {1'b0, 16'h0000, 4'b1000, 2'b11, 16'h8000},
    {1'b0, 16'h0000, 4'b0000, 2'b00, 16'h8000},
    {1'b0, 16'h0000, 4'b0001, 2'b10, 16'h8000},
    {1'b0, 16'h0000, 4'b1000, 2'b11, 16'h8000},
    {1'b1, 16'h0000, 4'b0000, 2'b00, 16'h0000},
    {1'b0, 16'h0000, 4'b0000, 2'b00, 16'h0000},
    {1'b0, 16'h0000, 4'b0010, 2'b10, 16'h0000},
    {1'b0, 16'h0000, 4'b0000, 2'b11, 16'h0000},
    {1'b0, 16'h0000, 4'b0100, 2'b11, 16'h0000},
    {1'b1, 16'hFFFF, 4'b1000, 2'b11, 16'hCF00},
    {1'b0, 16'h0000, 4'b0100, 2'b00, 16'hCF00},
    {1'b0, 16'h0000, 4'b0010, 2'b10, 16'hCF00},
    {1'b0, 16'h0000, 4'b1000, 2'b11, 16'hCF00}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [15:0] cfg_wr_data;
  logic [15:0] cfg_rd_data;
  logic        ctrl_busy, banks_precharged, cpu_wake_req, disp_wake_req;
  logic        sdram_cke, sdram_ready;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sdram_cke_pwr_ctrl uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_wr_en        (cfg_wr_en),
    .cfg_wr_data      (cfg_wr_data),
    .cfg_rd_data      (cfg_rd_data),
    .ctrl_busy        (ctrl_busy),
    .banks_precharged (banks_precharged),
    .cpu_wake_req     (cpu_wake_req),
    .disp_wake_req    (disp_wake_req),
    .sdram_cke        (sdram_cke),
    .sdram_ready      (sdram_ready)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [15:0] wd, input logic b,
                       input logic p, input logic c, input logic d);
    cfg_wr_en = wr; cfg_wr_data = wd; ctrl_busy = b;
    banks_precharged = p; cpu_wake_req = c; disp_wake_req = d;
  endtask

  task automatic write_cfg(input logic [15:0] val, input logic [15:0] exp_rd);
    drive(1'b1, val, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 R3 readback", cfg_rd_data, exp_rd);
    drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic wake_cpu();
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 cke after cpu wake", {15'd0, sdram_cke}, 16'd1);
    check("R9 ready low in exit", {15'd0, sdram_ready}, 16'd0);
    drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 ready back", {15'd0, sdram_ready}, 16'd1);
  endtask

  task automatic idle_run(input int n, input string req);
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (n - 1) @(negedge clk);
    check({req, " one before limit"}, {15'd0, sdram_cke}, 16'd1);
    @(negedge clk);
    check({req, " at limit"}, {15'd0, sdram_cke}, 16'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R2 reset readback", cfg_rd_data, 16'h0000);
    check("R2 reset cke/ready", {14'd0, sdram_cke, sdram_ready}, 16'd3);
    rst_n = 1'b1;
    drive(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R2 after release", {14'd0, sdram_cke, sdram_ready}, 16'd3);

    // table: R1 R3 R4 R5 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][38], VEC[i][37:22], VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18]);
      @(negedge clk);
      check($sformatf("R5 R8 R9 R10 table row %0d cke/ready", i),
            {14'd0, sdram_cke, sdram_ready}, {14'd0, VEC[i][17:16]});
      check($sformatf("R1 R3 R4 table row %0d readback", i), cfg_rd_data, VEC[i][15:0]);
    end

    // R3: reserved bits alone
    write_cfg(16'h30FF, 16'h0000);

    // R6: timeout 1
    write_cfg(16'h4100, 16'h4100);
    idle_run(UNIT, "R6 T=1");

    // R7: busy cycle mid-count
    wake_cpu();
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    check("R7 still up mid-count", {15'd0, sdram_cke}, 16'd1);
    drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    idle_run(UNIT, "R7 after busy");

    // R7: precharged drop mid-count, wake by display
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 cke after display wake", {14'd0, sdram_cke, sdram_ready}, 16'd2);
    drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 ready after display wake", {15'd0, sdram_ready}, 16'd1);
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R7 up across precharge drop", {15'd0, sdram_cke}, 16'd1);
    idle_run(UNIT, "R7 after precharge drop");

    // R6: timeout 2
    wake_cpu();
    write_cfg(16'h4200, 16'h4200);
    idle_run(2 * UNIT, "R6 T=2");

    // R11: zero timeout disables timed entry
    wake_cpu();
    write_cfg(16'h4000, 16'h4000);
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (2100) @(negedge clk);
    check("R11 zero timeout stays up", {15'd0, sdram_cke}, 16'd1);

    // R12: wake request blocks immediate entry
    write_cfg(16'h8000, 16'h8000);
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R12 cpu request blocks entry", {15'd0, sdram_cke}, 16'd1);
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R12 display request blocks entry", {15'd0, sdram_cke}, 16'd1);
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R5 entry once request clears", {15'd0, sdram_cke}, 16'd0);

    // R2: reset while powered down
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 reset while down", {14'd0, sdram_cke, sdram_ready}, 16'd3);
    check("R2 reset clears word", cfg_rd_data, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule